// File: doc/BRIEF.md
# Memory-Card Command Path Controller

This block drives the command side of a memory-card host. Software first loads a 32-bit argument and then writes a command word. If the enable bit is set and the path is idle, the block latches the command and raises a request toward the card-side logic. That request presents the 6-bit command index, the argument, and two qualifiers: whether a response is expected and whether that response is long. The request stays up until the card side acknowledges it.

A command that expects no response ends at the acknowledge. A command that expects a response waits for one of two things: a response-valid strobe, or a timeout tick. A strobe brings in a 128-bit payload and an echoed index, which land in four 32-bit response words and a response-index register. The outcome is recorded in sticky flags, which software clears through a write mask.

Serialization of bits on the card line and CRC7 generation happen elsewhere. The card side reports only two verdicts here: whether the CRC was good and whether a start bit was seen.

Top module: `cmd_path`

## Requirements
- R1: After reset there is no request, every status bit is zero and the response words and echoed index are zero. A command write with bit 10 set while idle raises `cardReq` on the next cycle and holds it until `cardAck`. While it is raised, `cardIndex` = command bits 5:0, `cardWantResp` = bit 6, `cardLongResp` = bit 7 and `cardArg` = the last argument written. Status bit 11 (busy) is high while a request is pending or a response is awaited.
- R2: A command with bit 6 clear ends when it is acknowledged. The cycle after the acknowledge, status bit 7 (sent) is set and busy is clear.
- R3: A command with bit 6 set waits after the acknowledge. A response-valid with both `crcOk` and `startBitOk` high sets status bit 6 (response end) and stores `respIndex` in `respCmd`.
- R4: A short response (bit 7 clear) writes payload bits 31:0 into response word 0, which is `respRegs[31:0]`, and leaves words 1 to 3 unchanged.
- R5: A long response writes payload word k (bits 32k+31:32k) into response word k for k = 0..3, so the most significant word lands in word 3.
- R6: If `crcOk` is low at a valid response that has a good start bit, status bit 0 (CRC fail) is set instead of bit 6. The response words and `respCmd` are still updated.
- R7: If `startBitOk` is low at a valid response, status bit 9 (start-bit error) is set. Neither bit 6 nor bit 0 is set, and the response words and `respCmd` keep their old values.
- R8: While a response is awaited, `timeoutTick` without `respValid` sets status bit 2 (timeout) and ends the command. When both arrive in the same cycle, the response wins.
- R9: Status bits 0, 2, 6, 7 and 9 stay set until a clear write with the matching bit of `clearMask` set. A flag set and cleared in the same cycle ends up set.
- R10: A command write with bit 10 clear returns the path to idle from any state, and the next cycle shows `cardReq` and busy low.
- R11: A command write with bit 10 set while the path is not idle is ignored. The latched index and qualifiers do not change and the transaction in progress continues.
- R12: Command bits 8 and 9 have no effect on the sequence or on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| argWrEn | input | 1 | Argument write strobe |
| argWrData | input | WORD_W | Argument value |
| cmdWrEn | input | 1 | Command write strobe |
| cmdWrData | input | 11 | Command word: index 5:0, response 6, long 7, bits 8 and 9 unused, enable 10 |
| clearEn | input | 1 | Flag clear strobe |
| clearMask | input | 11 | Flags to clear, one bit per status bit 10:0 |
| cardReq | output | 1 | Command request to card side |
| cardAck | input | 1 | Card side accepts the request |
| cardIndex | output | IDX_W | Latched command index |
| cardArg | output | WORD_W | Argument register |
| cardWantResp | output | 1 | Response expected |
| cardLongResp | output | 1 | Long response expected |
| respValid | input | 1 | Response received strobe |
| respIndex | input | IDX_W | Index echoed in the response |
| respPayload | input | RESP_WORDS*WORD_W | Response payload |
| timeoutTick | input | 1 | Response window expired |
| crcOk | input | 1 | Response CRC good |
| startBitOk | input | 1 | Response start bit seen |
| status | output | 12 | Sticky flags 10:0 plus busy at bit 11 |
| respRegs | output | RESP_WORDS*WORD_W | Response words, word k at bits 32k+31:32k |
| respCmd | output | IDX_W | Captured echoed index |

## Verification
The bench builds the block with its default sizes: 32-bit words, four response words and a 6-bit index. With these sizes, a long response is exactly four words, so the word ordering of long and short captures can be told apart bit for bit. A behavioural model of the four phases predicts every output on every cycle. The stimulus reaches each exit of each phase: acknowledge, response with each verdict combination, timeout alone, and timeout together with a response. It also covers aborts from every non-idle state, starts ignored in busy and done states, and clears that collide with sets.

// File: rtl/cmd_path_pkg.sv
package cmd_path_pkg;

  localparam int CMD_W   = 11;
  localparam int STAT_W  = 12;
  localparam int FLAG_W  = STAT_W - 1;

  // command word fields
  localparam int CMD_IDX_LSB = 0;
  localparam int CMD_RESP    = 6;
  localparam int CMD_LONG    = 7;
  localparam int CMD_EN      = 10;

  // status bit positions
  localparam int ST_CRCFAIL  = 0;
  localparam int ST_TIMEOUT  = 2;
  localparam int ST_RESPEND  = 6;
  localparam int ST_SENT     = 7;
  localparam int ST_STARTERR = 9;
  localparam int ST_BUSY     = 11;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SEND = 2'd1,
    PH_WAIT = 2'd2,
    PH_DONE = 2'd3
  } phase_t;

  typedef struct packed {
    logic latchCmd;
    logic setSent;
    logic setRespEnd;
    logic setCrcFail;
    logic setTimeout;
    logic setStartErr;
    logic capture;
  } cmdStrobe_t;

endpackage

// File: rtl/cmd_path_ctrl.sv
module cmd_path_ctrl
  import cmd_path_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWrEn,
  input  logic       cmdEnBit,
  input  logic       waitResp,
  input  logic       cardAck,
  input  logic       respValid,
  input  logic       timeoutTick,
  input  logic       crcOk,
  input  logic       startBitOk,
  output cmdStrobe_t strobe,
  output logic       reqOut,
  output logic       busy
);

  phase_t phase, nextPhase;
  logic   abort;

  assign abort = cmdWrEn && !cmdEnBit;

  always_comb begin
    nextPhase = phase;
    strobe    = '0;
    unique case (phase)
      PH_IDLE: begin
        if (cmdWrEn && cmdEnBit) begin
          nextPhase       = PH_SEND;
          strobe.latchCmd = 1'b1;
        end
      end
      PH_SEND: begin
        if (abort) begin
          nextPhase = PH_IDLE;
        end else if (cardAck) begin
          if (waitResp) begin
            nextPhase = PH_WAIT;
          end else begin
            nextPhase      = PH_DONE;
            strobe.setSent = 1'b1;
          end
        end
      end
      PH_WAIT: begin
        if (abort) begin
          nextPhase = PH_IDLE;
        end else if (respValid) begin
          nextPhase = PH_DONE;
          if (!startBitOk) begin
            strobe.setStartErr = 1'b1;
          end else begin
            strobe.capture    = 1'b1;
            strobe.setRespEnd = crcOk;
            strobe.setCrcFail = !crcOk;
          end
        end else if (timeoutTick) begin
          nextPhase         = PH_DONE;
          strobe.setTimeout = 1'b1;
        end
      end
      PH_DONE: begin
        if (abort) nextPhase = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= nextPhase;
  end

  assign reqOut = (phase == PH_SEND);
  assign busy   = (phase == PH_SEND) || (phase == PH_WAIT);

endmodule

// File: rtl/cmd_path_data.sv
module cmd_path_data
  import cmd_path_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int RESP_WORDS = 4,
  parameter int IDX_W      = 6,
  localparam int RESP_W    = WORD_W * RESP_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strobe,
  input  logic              argWrEn,
  input  logic [WORD_W-1:0] argWrData,
  input  logic [IDX_W-1:0]  cmdIndexIn,
  input  logic              cmdRespIn,
  input  logic              cmdLongIn,
  input  logic              clearEn,
  input  logic [FLAG_W-1:0] clearMask,
  input  logic [IDX_W-1:0]  respIndex,
  input  logic [RESP_W-1:0] respPayload,
  output logic [WORD_W-1:0] argOut,
  output logic [IDX_W-1:0]  indexOut,
  output logic              wantResp,
  output logic              longResp,
  output logic [FLAG_W-1:0] flags,
  output logic [RESP_W-1:0] respRegs,
  output logic [IDX_W-1:0]  respCmd
);

  logic [FLAG_W-1:0] setVec;
  logic [FLAG_W-1:0] clrVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) argOut <= '0;
    else if (argWrEn) argOut <= argWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      indexOut <= '0;
      wantResp <= 1'b0;
      longResp <= 1'b0;
    end else if (strobe.latchCmd) begin
      indexOut <= cmdIndexIn;
      wantResp <= cmdRespIn;
      longResp <= cmdLongIn;
    end
  end

  always_comb begin
    setVec              = '0;
    setVec[ST_CRCFAIL]  = strobe.setCrcFail;
    setVec[ST_TIMEOUT]  = strobe.setTimeout;
    setVec[ST_RESPEND]  = strobe.setRespEnd;
    setVec[ST_SENT]     = strobe.setSent;
    setVec[ST_STARTERR] = strobe.setStartErr;
  end

  assign clrVec = clearEn ? clearMask : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrVec) | setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) respCmd <= '0;
    else if (strobe.capture) respCmd <= respIndex;
  end

  for (genvar w = 0; w < RESP_WORDS; w++) begin : gWord
    logic [WORD_W-1:0] word;
    logic              loadW;
    assign loadW = strobe.capture && ((w == 0) || longResp);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      word <= '0;
      else if (loadW) word <= respPayload[w*WORD_W +: WORD_W];
    end
    assign respRegs[w*WORD_W +: WORD_W] = word;
  end

endmodule

// File: rtl/cmd_path.sv
module cmd_path
  import cmd_path_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int RESP_WORDS = 4,
  parameter int IDX_W      = 6,
  localparam int RESP_W    = WORD_W * RESP_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              argWrEn,
  input  logic [WORD_W-1:0] argWrData,
  input  logic              cmdWrEn,
  input  logic [CMD_W-1:0]  cmdWrData,
  input  logic              clearEn,
  input  logic [FLAG_W-1:0] clearMask,
  output logic              cardReq,
  input  logic              cardAck,
  output logic [IDX_W-1:0]  cardIndex,
  output logic [WORD_W-1:0] cardArg,
  output logic              cardWantResp,
  output logic              cardLongResp,
  input  logic              respValid,
  input  logic [IDX_W-1:0]  respIndex,
  input  logic [RESP_W-1:0] respPayload,
  input  logic              timeoutTick,
  input  logic              crcOk,
  input  logic              startBitOk,
  output logic [STAT_W-1:0] status,
  output logic [RESP_W-1:0] respRegs,
  output logic [IDX_W-1:0]  respCmd
);

  cmdStrobe_t        strobe;
  logic              busy;
  logic [FLAG_W-1:0] flags;
  logic              unusedCmdBits;

  // hold bits 9:8 carry no behaviour in this path
  assign unusedCmdBits = ^cmdWrData[CMD_EN-1:CMD_LONG+1];

  cmd_path_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWrEn    (cmdWrEn),
    .cmdEnBit   (cmdWrData[CMD_EN]),
    .waitResp   (cardWantResp),
    .cardAck    (cardAck),
    .respValid  (respValid),
    .timeoutTick(timeoutTick),
    .crcOk      (crcOk),
    .startBitOk (startBitOk),
    .strobe     (strobe),
    .reqOut     (cardReq),
    .busy       (busy)
  );

  cmd_path_data #(
    .WORD_W    (WORD_W),
    .RESP_WORDS(RESP_WORDS),
    .IDX_W     (IDX_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .argWrEn    (argWrEn),
    .argWrData  (argWrData),
    .cmdIndexIn (cmdWrData[CMD_IDX_LSB +: IDX_W]),
    .cmdRespIn  (cmdWrData[CMD_RESP]),
    .cmdLongIn  (cmdWrData[CMD_LONG]),
    .clearEn    (clearEn),
    .clearMask  (clearMask),
    .respIndex  (respIndex),
    .respPayload(respPayload),
    .argOut     (cardArg),
    .indexOut   (cardIndex),
    .wantResp   (cardWantResp),
    .longResp   (cardLongResp),
    .flags      (flags),
    .respRegs   (respRegs),
    .respCmd    (respCmd)
  );

  assign status = {busy, flags};

endmodule

// File: rtl/cmd_path_sva.sv
module cmd_path_sva
  import cmd_path_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int RESP_WORDS = 4,
  localparam int RESP_W    = WORD_W * RESP_WORDS
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWrEn,
  input logic [CMD_W-1:0]  cmdWrData,
  input logic              clearEn,
  input logic [FLAG_W-1:0] clearMask,
  input logic              cardReq,
  input logic              cardAck,
  input logic              cardWantResp,
  input logic              cardLongResp,
  input logic              respValid,
  input logic              timeoutTick,
  input logic              startBitOk,
  input logic [STAT_W-1:0] status,
  input logic [RESP_W-1:0] respRegs
);

  logic abortWr;
  logic inWait;
  assign abortWr = cmdWrEn && !cmdWrData[CMD_EN];
  assign inWait  = status[ST_BUSY] && !cardReq;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    cardReq && !cardAck && !abortWr |=> cardReq); // R1

  AST_SENT_ON_ACK: assert property (@(posedge clk) disable iff (!rstN)
    cardReq && cardAck && !cardWantResp && !abortWr |=> status[ST_SENT] && !status[ST_BUSY]); // R2

  AST_WAIT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    cardReq && cardAck && cardWantResp && !abortWr |=> inWait); // R3

  AST_SHORT_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    inWait && respValid && !cardLongResp && !abortWr |=> $stable(respRegs[RESP_W-1:WORD_W])); // R4

  AST_STARTERR_KEEPS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    inWait && respValid && !startBitOk && !abortWr |=> $stable(respRegs) && status[ST_STARTERR]); // R7

  AST_TIMEOUT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    inWait && timeoutTick && !respValid && !abortWr |=> status[ST_TIMEOUT] && !status[ST_BUSY]); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    status[ST_SENT] && !(clearEn && clearMask[ST_SENT]) |=> status[ST_SENT]); // R9

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    abortWr |=> !cardReq && !status[ST_BUSY]); // R10

endmodule

bind cmd_path cmd_path_sva #(.WORD_W(WORD_W), .RESP_WORDS(RESP_WORDS)) uChk (.*);

// File: tb/cmd_path_test.sv
`timescale 1ns/1ps
module cmd_path_test;
  localparam int WW = 32;
  localparam int NW = 4;
  localparam int IW = 6;
  localparam int RW = WW * NW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          argWrEn = 0, cmdWrEn = 0, clearEn = 0;
  logic [WW-1:0] argWrData = '0;
  logic [10:0]   cmdWrData = '0;
  logic [10:0]   clearMask = '0;
  logic          cardAck = 0, respValid = 0, timeoutTick = 0;
  logic          crcOk = 1, startBitOk = 1;
  logic [IW-1:0] respIndex = '0;
  logic [RW-1:0] respPayload = '0;
  logic          cardReq, cardWantResp, cardLongResp;
  logic [IW-1:0] cardIndex, respCmd;
  logic [WW-1:0] cardArg;
  logic [11:0]   status;
  logic [RW-1:0] respRegs;

  cmd_path uut (.*);

  always #2.5 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  bit    finished = 0;
  string curTag = "R1 reset";

  // behavioural reference
  int            mState = 0; // 0 idle 1 send 2 wait 3 done
  logic [10:0]   mCmd = '0;
  logic [WW-1:0] mArg = '0;
  logic [10:0]   mFlags = '0;
  logic [RW-1:0] mResp = '0;
  logic [IW-1:0] mRespCmd = '0;

  task automatic modelUpdate();
    logic [10:0] setV;
    bit abort;
    if (!rstN) begin
      mState = 0; mCmd = '0; mArg = '0; mFlags = '0; mResp = '0; mRespCmd = '0;
      return;
    end
    setV  = '0;
    abort = cmdWrEn && !cmdWrData[10];
    if (argWrEn) mArg = argWrData;
    case (mState)
      0: if (cmdWrEn && cmdWrData[10]) begin mCmd = cmdWrData; mState = 1; end
      1: if (abort) mState = 0;
         else if (cardAck) begin
           if (mCmd[6]) mState = 2;
           else begin setV[7] = 1'b1; mState = 3; end
         end
      2: if (abort) mState = 0;
         else if (respValid) begin
           if (!startBitOk) setV[9] = 1'b1;
           else begin
             mRespCmd = respIndex;
             if (mCmd[7]) mResp = respPayload;
             else mResp[31:0] = respPayload[31:0];
             if (crcOk) setV[6] = 1'b1; else setV[0] = 1'b1;
           end
           mState = 3;
         end else if (timeoutTick) begin
           setV[2] = 1'b1; mState = 3;
         end
      default: if (abort) mState = 0;
    endcase
    if (clearEn) mFlags = mFlags & ~clearMask;
    mFlags = mFlags | setV;
  endtask

  task automatic chk(string what, logic [RW-1:0] act, logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", curTag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("cardReq", RW'(cardReq), RW'(mState == 1));
    chk("cardIndex", RW'(cardIndex), RW'(mCmd[5:0]));
    chk("cardArg", RW'(cardArg), RW'(mArg));
    chk("cardWantResp", RW'(cardWantResp), RW'(mCmd[6]));
    chk("cardLongResp", RW'(cardLongResp), RW'(mCmd[7]));
    chk("status", RW'(status), RW'({(mState == 1 || mState == 2), mFlags}));
    chk("respRegs", respRegs, mResp);
    chk("respCmd", RW'(respCmd), RW'(mRespCmd));
  endtask

  task automatic step();
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    compareAll();
    argWrEn = 0; cmdWrEn = 0; clearEn = 0; cardAck = 0;
    respValid = 0; timeoutTick = 0; crcOk = 1; startBitOk = 1;
  endtask

  task automatic wrCmd(logic [10:0] w);
    cmdWrEn = 1; cmdWrData = w; step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic resp(logic [IW-1:0] idx, logic [RW-1:0] pl, logic c, logic s);
    respValid = 1; respIndex = idx; respPayload = pl; crcOk = c; startBitOk = s; step();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    idle(3);
    rstN = 1;
    curTag = "R1 reset state"; idle(1);

    curTag = "R1 start and hold request";
    argWrEn = 1; argWrData = 32'h1234_5678; step();
    wrCmd(11'h400 | 11'd5);
    idle(2);
    curTag = "R2 sent on ack";
    cardAck = 1; step(); idle(2);
    curTag = "R9 sticky then clear";
    clearEn = 1; clearMask = 11'h004; step();
    clearEn = 1; clearMask = 11'h080; step(); idle(1);
    curTag = "R10 leave done";
    wrCmd(11'h000); idle(1);

    curTag = "R3 short response";
    argWrEn = 1; argWrData = 32'hCAFE_0001; step();
    wrCmd(11'h440 | 11'd17);
    cardAck = 1; step(); idle(2);
    curTag = "R4 short load word0";
    resp(6'd17, {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111}, 1, 1);
    idle(1); wrCmd(11'h000);

    curTag = "R5 long response R12 hold bits";
    wrCmd(11'h7C0 | 11'd2);
    cardAck = 1; step();
    resp(6'd63, {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000}, 1, 1);
    wrCmd(11'h000);
    curTag = "R4 short keeps upper words";
    wrCmd(11'h440 | 11'd9); cardAck = 1; step();
    resp(6'd9, {32'h0, 32'h0, 32'h0, 32'h5555_AAAA}, 1, 1);
    wrCmd(11'h000);

    curTag = "R6 crc fail";
    clearEn = 1; clearMask = 11'h7FF; step();
    wrCmd(11'h440 | 11'd13); cardAck = 1; step();
    resp(6'd13, {4{32'h9876_0013}}, 0, 1);
    wrCmd(11'h000);

    curTag = "R7 start bit error";
    wrCmd(11'h4C0 | 11'd14); cardAck = 1; step();
    resp(6'd14, {4{32'hEEEE_EEEE}}, 0, 0);
    wrCmd(11'h000);

    curTag = "R8 timeout";
    wrCmd(11'h440 | 11'd8); cardAck = 1; step(); idle(3);
    timeoutTick = 1; step(); wrCmd(11'h000);
    curTag = "R8 response wins over tick";
    clearEn = 1; clearMask = 11'h7FF; step();
    wrCmd(11'h440 | 11'd7); cardAck = 1; step();
    timeoutTick = 1; resp(6'd7, {4{32'h0707_0707}}, 1, 1);
    wrCmd(11'h000);

    curTag = "R9 set beats clear";
    wrCmd(11'h440 | 11'd3); cardAck = 1; step();
    clearEn = 1; clearMask = 11'h7FF; resp(6'd3, {4{32'h0303_0303}}, 1, 1);
    wrCmd(11'h000);

    curTag = "R10 abort in send";
    wrCmd(11'h440 | 11'd21); idle(1); wrCmd(11'h000); idle(1);
    curTag = "R10 abort in wait";
    wrCmd(11'h440 | 11'd22); cardAck = 1; step(); wrCmd(11'h000);
    respValid = 1; respPayload = '1; step(); idle(1);

    curTag = "R11 start ignored in send";
    wrCmd(11'h400 | 11'd30); wrCmd(11'h4C0 | 11'd31); idle(1);
    cardAck = 1; step();
    curTag = "R11 start ignored in done";
    wrCmd(11'h440 | 11'd40); idle(2);
    wrCmd(11'h000); idle(2);

    finish();
  end
endmodule